// File: doc/BRIEF.md
# Dual-Write Memory with Location Table

This block is a small memory that accepts two writes and one read in every clock cycle. It does not duplicate the address space. Physical storage is three banks of half the logical depth each: two home banks and one spare bank. A location table keeps one bit per logical address. That bit records whether the newest value of the address sits in its home bank or in the spare bank.

A logical address `a` has home bank `a[0]` and row `a >> 1`. The two logical addresses that share a row are called partners. Together they own three physical slots: one in each home bank and one in the spare bank. Both write ports first look up the bank that currently holds their address. When the two writes land in different banks, each writes in place. When they land in the same bank, port 0 keeps its place and port 1 moves to the one free slot of its row. The location table is then rewritten so that later reads find the new slot.

A read takes one cycle. It looks up the location of its address and registers the word held there.

Top module: `dual_write_remap_mem`

## Requirements
- R1: After reset every location entry names the home bank, and every logical address reads as zero. `rd_valid` is low until the first read.
- R2: A read returns the most recent value written to its logical address. A write in the same cycle as the read becomes visible from the next cycle on.
- R3: Two writes whose current banks differ are both stored in place in the same cycle.
- R4: If both writes are held in the same home bank (home bank = address bit 0, row = upper address bits), port 0 writes in place. Port 1 is written to the spare bank (identifier 2) at its own row, and its location entry is set so reads use the spare bank from the next cycle.
- R5: If both writes are held in the spare bank, port 0 writes in place and port 1 is written back to its home bank. Its location entry returns to home.
- R6: If port 1 must move to the spare bank while that row's spare slot holds its partner, the partner's word is copied back to the partner's home bank in the same cycle. The partner's entry returns to home, so no stored value is lost.
- R7: If both writes name the same logical address, only port 1's data is stored.
- R8: The location table holds (ceil(log2(2+1)) - 1) x depth = one bit per logical address. At most one of two partners is ever marked as held in the spare bank.
- R9: No physical bank receives more than one write in any cycle.
- R10: `rd_valid` is high exactly one cycle after `rd_en` was high. `rd_data` is valid while `rd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | ADDR_W | Write port 0 logical address |
| wr0_data | input | DATA_W | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_addr | input | ADDR_W | Write port 1 logical address |
| wr1_data | input | DATA_W | Write port 1 data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read logical address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | DATA_W | Read data |

## Verification
Two functions can fall in the same cycle here: a bank conflict that moves port 1 into the spare bank, and the eviction of a partner already sitting in that spare slot. Directed sequences build these cases on purpose. One sequence parks an address in the spare bank and then forces its partner to collide. Another parks two addresses in the spare bank and writes both together. A random phase then confines all three ports to a few rows, so moves, evictions and returns occur back to back with reads of the same addresses. Every read is compared against a plain per-address model that does not know where data lives.

// File: rtl/wpx_pkg.sv
package wpx_pkg;
  typedef enum logic [1:0] {
    BK_HOME0 = 2'd0,
    BK_HOME1 = 2'd1,
    BK_SPARE = 2'd2
  } bank_id_e;

  localparam int unsigned NUM_HOME_BANKS = 2;
  localparam int unsigned NUM_BANKS      = NUM_HOME_BANKS + 1;
endpackage

// File: rtl/wpx_bank.sv
module wpx_bank #(
  parameter int unsigned ROWS   = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NRD    = 1,
  localparam int unsigned OFF_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [OFF_W-1:0]             waddr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NRD-1:0][OFF_W-1:0]    raddr,
  output logic [NRD-1:0][DATA_W-1:0]   rdata
);
  logic [ROWS-1:0][DATA_W-1:0] mem_q;
  logic [ROWS-1:0][DATA_W-1:0] mem_nxt;

  always_comb begin
    mem_nxt = mem_q;
    if (we) begin
      mem_nxt[waddr] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (we) begin
      mem_q <= mem_nxt;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem_q[raddr[p]];
  end
endmodule

// File: rtl/wpx_remap.sv
module wpx_remap #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned ADDR_W   = $clog2(DEPTH),
  localparam int unsigned TBL_BITS = ($clog2(wpx_pkg::NUM_HOME_BANKS + 1) - 1) * DEPTH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [ADDR_W-1:0]   set_addr,
  input  logic                set_spare,
  input  logic                clr_en,
  input  logic [ADDR_W-1:0]   clr_addr,
  output logic [TBL_BITS-1:0] in_spare
);
  logic [TBL_BITS-1:0] tbl_q;
  logic [TBL_BITS-1:0] tbl_nxt;
  logic                tbl_ce;

  assign tbl_ce = set_en | clr_en;

  always_comb begin
    tbl_nxt = tbl_q;
    if (clr_en) begin
      tbl_nxt[clr_addr] = 1'b0;
    end
    if (set_en) begin
      tbl_nxt[set_addr] = set_spare;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q <= '0;
    end else if (tbl_ce) begin
      tbl_q <= tbl_nxt;
    end
  end

  assign in_spare = tbl_q;

  // R8: two partners never both claim the spare slot of their row
  for (genvar r = 0; r < DEPTH / 2; r++) begin : g_chk
    p_one_spare_per_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(tbl_q[2*r] && tbl_q[2*r+1]));
  end

  // R4: a table update is visible in the following cycle
  p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (tbl_q[$past(set_addr)] == $past(set_spare)));
endmodule

// File: rtl/wpx_steer.sv
module wpx_steer #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en0,
  input  logic [ADDR_W-1:0]    addr0,
  input  wpx_pkg::bank_id_e    cur0,
  input  logic                 en1,
  input  logic [ADDR_W-1:0]    addr1,
  input  wpx_pkg::bank_id_e    cur1,
  input  logic                 partner_spare,
  output logic                 go0,
  output logic                 go1,
  output wpx_pkg::bank_id_e    tgt0,
  output wpx_pkg::bank_id_e    tgt1,
  output logic                 evict,
  output logic                 moved,
  output logic                 moved_spare
);
  import wpx_pkg::*;

  logic     same_addr;
  logic     clash;
  bank_id_e home1;

  assign same_addr = en0 && en1 && (addr0 == addr1);
  assign go0       = en0 && !same_addr;
  assign go1       = en1;
  assign clash     = go0 && go1 && (cur0 == cur1);
  assign home1     = bank_id_e'({1'b0, addr1[0]});

  always_comb begin
    tgt0 = cur0;
    tgt1 = cur1;
    if (clash) begin
      tgt1 = (cur1 == BK_SPARE) ? home1 : BK_SPARE;
    end
  end

  assign evict       = clash && (cur1 != BK_SPARE) && partner_spare;
  assign moved       = clash;
  assign moved_spare = clash && (cur1 != BK_SPARE);

  // R9: the two effective writes never share a bank
  p_ports_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go0 && go1) |-> (tgt0 != tgt1));

  // R6: an eviction only accompanies a move into the spare bank
  p_evict_with_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evict |-> (tgt1 == BK_SPARE));

  // R7: a same-address pair never produces two writes
  p_same_addr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en0 && en1 && (addr0 == addr1)) |-> !(go0 && go1));
endmodule

// File: rtl/dual_write_remap_mem.sv
module dual_write_remap_mem #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned ROWS   = DEPTH / 2,
  localparam int unsigned OFF_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr0_en,
  input  logic [ADDR_W-1:0] wr0_addr,
  input  logic [DATA_W-1:0] wr0_data,
  input  logic              wr1_en,
  input  logic [ADDR_W-1:0] wr1_addr,
  input  logic [DATA_W-1:0] wr1_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  import wpx_pkg::*;

  logic [DEPTH-1:0] in_spare;
  bank_id_e         cur0, cur1, cur_rd;
  logic             partner_spare;
  logic [ADDR_W-1:0] partner_addr;

  logic     go0, go1, evict, moved, moved_spare;
  bank_id_e tgt0, tgt1;

  logic [OFF_W-1:0] off0, off1, off_rd;

  logic [NUM_BANKS-1:0]             bk_we;
  logic [NUM_BANKS-1:0][OFF_W-1:0]  bk_waddr;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bk_wdata;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bk_rword;
  logic [DATA_W-1:0]                evict_word;

  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;
  logic [DATA_W-1:0] rd_data_nxt;

  function automatic bank_id_e locate(input logic [ADDR_W-1:0] a,
                                      input logic [DEPTH-1:0] tbl);
    return tbl[a] ? BK_SPARE : bank_id_e'({1'b0, a[0]});
  endfunction

  assign off0   = wr0_addr[ADDR_W-1:1];
  assign off1   = wr1_addr[ADDR_W-1:1];
  assign off_rd = rd_addr[ADDR_W-1:1];

  assign cur0          = locate(wr0_addr, in_spare);
  assign cur1          = locate(wr1_addr, in_spare);
  assign cur_rd        = locate(rd_addr, in_spare);
  assign partner_addr  = wr1_addr ^ {{(ADDR_W-1){1'b0}}, 1'b1};
  assign partner_spare = in_spare[partner_addr];

  wpx_remap #(.DEPTH(DEPTH)) u_remap (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (go1 && moved),
    .set_addr  (wr1_addr),
    .set_spare (moved_spare),
    .clr_en    (evict),
    .clr_addr  (partner_addr),
    .in_spare  (in_spare)
  );

  wpx_steer #(.ADDR_W(ADDR_W)) u_steer (
    .clk           (clk),
    .rst_n         (rst_n),
    .en0           (wr0_en),
    .addr0         (wr0_addr),
    .cur0          (cur0),
    .en1           (wr1_en),
    .addr1         (wr1_addr),
    .cur1          (cur1),
    .partner_spare (partner_spare),
    .go0           (go0),
    .go1           (go1),
    .tgt0          (tgt0),
    .tgt1          (tgt1),
    .evict         (evict),
    .moved         (moved),
    .moved_spare   (moved_spare)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic hit0, hit1, hit_ev;
    assign hit0   = go0 && (tgt0 == bank_id_e'(k));
    assign hit1   = go1 && (tgt1 == bank_id_e'(k));
    assign hit_ev = evict && (k < NUM_HOME_BANKS) && (partner_addr[0] == k[0]);

    always_comb begin
      bk_we[k]    = hit0 | hit1 | hit_ev;
      bk_waddr[k] = off1;
      bk_wdata[k] = wr1_data;
      if (hit0) begin
        bk_waddr[k] = off0;
        bk_wdata[k] = wr0_data;
      end else if (hit_ev) begin
        bk_waddr[k] = off1;
        bk_wdata[k] = evict_word;
      end
    end

    if (k == int'(BK_SPARE)) begin : g_spare
      logic [1:0][OFF_W-1:0]  ra;
      logic [1:0][DATA_W-1:0] rw;
      assign ra[0] = off_rd;
      assign ra[1] = off1;
      wpx_bank #(.ROWS(ROWS), .DATA_W(DATA_W), .NRD(2)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bk_we[k]),
        .waddr (bk_waddr[k]),
        .wdata (bk_wdata[k]),
        .raddr (ra),
        .rdata (rw)
      );
      assign bk_rword[k] = rw[0];
      assign evict_word  = rw[1];
    end else begin : g_home
      logic [0:0][OFF_W-1:0]  ra;
      logic [0:0][DATA_W-1:0] rw;
      assign ra[0] = off_rd;
      wpx_bank #(.ROWS(ROWS), .DATA_W(DATA_W), .NRD(1)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bk_we[k]),
        .waddr (bk_waddr[k]),
        .wdata (bk_wdata[k]),
        .raddr (ra),
        .rdata (rw)
      );
      assign bk_rword[k] = rw[0];
    end

    // R9: one write per physical bank per cycle
    p_one_write_per_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({hit0, hit1, hit_ev}) <= 1);
  end

  assign rd_data_nxt = bk_rword[cur_rd];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else if (rd_en) begin
      rd_data_q <= rd_data_nxt;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // R10: read strobe is the request delayed by one cycle
  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  // R6: an evicted partner is marked home in the following cycle
  p_evicted_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evict |=> !in_spare[$past(partner_addr)]);
endmodule

// File: tb/dual_write_remap_mem_tb_top.sv
module dual_write_remap_mem_tb_top;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 16;
  localparam int AW     = $clog2(DEPTH);

  logic              clk;
  logic              rst_n;
  logic              wr0_en, wr1_en, rd_en;
  logic [AW-1:0]     wr0_addr, wr1_addr, rd_addr;
  logic [DATA_W-1:0] wr0_data, wr1_data;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;

  int checks;
  int errors;
  int ref_mem [DEPTH];

  dual_write_remap_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr0_en   (wr0_en),
    .wr0_addr (wr0_addr),
    .wr0_data (wr0_data),
    .wr1_en   (wr1_en),
    .wr1_addr (wr1_addr),
    .wr1_data (wr1_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic e0, input int a0, input int d0,
                     input logic e1, input int a1, input int d1,
                     input logic re, input int ra, input string tag);
    int exp_rd;
    wr0_en = e0; wr0_addr = AW'(a0); wr0_data = DATA_W'(d0);
    wr1_en = e1; wr1_addr = AW'(a1); wr1_data = DATA_W'(d1);
    rd_en  = re; rd_addr  = AW'(ra);
    exp_rd = ref_mem[ra];
    @(posedge clk);
    @(negedge clk);
    chk("R10", int'(rd_valid), int'(re));
    if (re) chk(tag, int'(rd_data), exp_rd);
    if (e0) ref_mem[a0] = d0 & 16'hFFFF;
    if (e1) ref_mem[a1] = d1 & 16'hFFFF;
    wr0_en = 1'b0; wr1_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    cyc(1'b0, 0, 0, 1'b0, 0, 0, 1'b1, a, tag);
  endtask

  initial begin
    checks = 0; errors = 0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 0;
    rst_n = 1'b0;
    wr0_en = 1'b0; wr1_en = 1'b0; rd_en = 1'b0;
    wr0_addr = '0; wr1_addr = '0; rd_addr = '0;
    wr0_data = '0; wr1_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(rd_valid), 0);
    for (int i = 0; i < DEPTH; i++) rd(i, "R1");

    // R3: different home banks
    cyc(1'b1, 2, 16'h1111, 1'b1, 3, 16'h2222, 1'b0, 0, "R3");
    rd(2, "R3"); rd(3, "R3");

    // R4: both in home bank 0, port 1 moves to spare row 3
    cyc(1'b1, 4, 16'hA004, 1'b1, 6, 16'hA006, 1'b1, 6, "R4");
    rd(4, "R4"); rd(6, "R4");

    // R6: partner 7 collides in home bank 1; 6 evicted home
    cyc(1'b1, 5, 16'hB005, 1'b1, 7, 16'hB007, 1'b1, 7, "R6");
    rd(6, "R6"); rd(7, "R6"); rd(5, "R6");

    // R5: put 10 into spare, then collide 7 and 10 in spare
    cyc(1'b1, 8, 16'hC008, 1'b1, 10, 16'hC00A, 1'b0, 0, "R4");
    rd(10, "R4");
    cyc(1'b1, 7, 16'hD007, 1'b1, 10, 16'hD00A, 1'b0, 0, "R5");
    rd(7, "R5"); rd(10, "R5"); rd(11, "R5");

    // R7: same address on both ports
    cyc(1'b1, 9, 16'hE0E0, 1'b1, 9, 16'hF0F0, 1'b0, 0, "R7");
    rd(9, "R7");

    // R2: read in the write cycle sees the old word, next cycle the new
    cyc(1'b1, 1, 16'h0101, 1'b0, 0, 0, 1'b1, 1, "R2");
    rd(1, "R2");

    // R8, R9: random traffic confined to few rows
    for (int n = 0; n < 3000; n++) begin
      cyc(1'($urandom), int'($urandom % 6), int'($urandom),
          1'($urandom), int'($urandom % 6), int'($urandom),
          1'($urandom), int'($urandom % 6), "R8");
    end
    for (int i = 0; i < DEPTH; i++) rd(i, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule